// File: doc/BRIEF.md
# Washing Machine Cycle Sequencer

This block runs one complete wash cycle for a domestic washing machine. It waits in an idle state until the start button is pressed on an update tick. At that moment it latches the selected program. It then steps through a fixed order of phases: locking the door, dosing detergent, filling with water, heating, washing with the motor, draining, and releasing the door. Each phase drives its own set of actuator outputs and waits for the sensor input that ends it.

Two bits of the program code decide whether the detergent and heating phases run or are skipped. During the wash phase a small step engine plays back a forward and reverse motor pattern that belongs to the program. Each step has its own direction, speed and length in ticks. The sequencer changes state only on a periodic update tick, so the clock can run much faster than the control rate while the phase timing stays tied to the tick.

Top module: `wm_cycle_seq`

## Requirements
- R1: A synchronous active-high reset returns the machine to idle with every actuator output low, motor speed 0 and `cycle_done` low, including when it arrives in the middle of a cycle.
- R2: A cycle begins only on a clock edge where `tick` and `start` are both high in idle. `prog_sel` is latched at that edge, and later changes to `prog_sel` have no effect on the running cycle. The first phase drives only `door_lock`.
- R3: State and outputs change only on edges where `tick` is high. Sensor inputs and `start` have no effect on clock edges without a tick.
- R4: When latched program bit 1 is 1, the detergent phase drives `door_lock`, `fill_valve` and `soap_hatch`. It ends on a tick that sees `soap_released`. When program bit 1 is 0, the machine goes straight from the lock phase to filling.
- R5: The fill phase drives `door_lock` and `fill_valve` only. It ends on a tick that sees `water_full`.
- R6: When latched program bit 0 is 1, filling is followed by a heating phase that drives `door_lock` and `heater_on` only. It ends on a tick that sees `temp_reached`. When program bit 0 is 0, filling is followed directly by washing.
- R7: The wash phase plays steps i = 0 .. STEPS-1 of program p in order. In step i, `motor_rev` equals i mod 2, `motor_speed` equals ((p+i) mod 3)+1, and the step lasts UNIT*(1+((p+i) mod 2)) ticks. `motor_speed` is 0 in every other phase.
- R8: The drain phase drives `door_lock` and `drain_pump` only. It ends on a tick that sees `drum_empty`.
- R9: After draining, a release phase drives every actuator low. On the next tick the machine returns to idle, and `cycle_done` is high for exactly one clock after that tick edge.
- R10: A start press while a cycle is running is ignored. The phase sequence and motor pattern continue unchanged.
- R11: The heater is never on together with the fill valve, the drain pump or the motor. The motor never runs unless the door is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Periodic update strobe, one clock wide |
| start | input | 1 | Start pushbutton |
| prog_sel | input | PROG_W | Program selection code |
| soap_released | input | 1 | Detergent has left the hatch |
| water_full | input | 1 | Drum full-level sensor |
| temp_reached | input | 1 | Water at target temperature |
| drum_empty | input | 1 | Drum empty sensor |
| door_lock | output | 1 | Door lock engaged |
| fill_valve | output | 1 | Water inlet valve open |
| soap_hatch | output | 1 | Detergent hatch open |
| heater_on | output | 1 | Water heater on |
| drain_pump | output | 1 | Drain pump on |
| motor_rev | output | 1 | Motor direction, 1 = reverse |
| motor_speed | output | 2 | Motor speed, 0 = stopped |
| cycle_done | output | 1 | One-clock pulse at end of cycle |

## Verification
The bench builds the block with PROG_W = 2, STEPS = 4 and UNIT = 2. The two-bit program code gives four programs, one for each combination of running or skipping the detergent and heating phases, and all four are run. With UNIT = 2, the motor steps last 2 or 4 ticks, so the step engine's tick counter moves through several values inside one step before it hands over to the next step. The program code also moves the speed pattern, so each program produces a different motor sequence.

// File: rtl/wm_pkg.sv
package wm_pkg;

    localparam int SPD_W = 2;
    localparam int DUR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOCK,
        ST_DOSE,
        ST_FILL,
        ST_HEAT,
        ST_WASH,
        ST_DRAIN,
        ST_RELEASE
    } cyc_state_t;

    typedef struct packed {
        logic             rev;
        logic [SPD_W-1:0] speed;
    } motor_cmd_t;

    typedef struct packed {
        logic             rev;
        logic [SPD_W-1:0] speed;
        logic [DUR_W-1:0] dur;
    } motor_step_t;

    typedef struct packed {
        logic use_soap;
        logic use_heat;
    } prog_cfg_t;

    typedef struct packed {
        logic lock;
        logic valve;
        logic hatch;
        logic heater;
        logic pump;
    } act_t;

    // Motor step for program p, position i, scaled by the tick unit
    function automatic motor_step_t step_of(input int p, input int i, input int unit);
        motor_step_t s;
        s.rev   = 1'((i % 2) == 1);
        s.speed = SPD_W'(((p + i) % 3) + 1);
        s.dur   = DUR_W'(unit * (1 + ((p + i) % 2)));
        return s;
    endfunction

    // Actuator pattern for each phase
    function automatic act_t act_of(input cyc_state_t st);
        act_t a;
        a = '0;
        case (st)
            ST_LOCK:  a.lock = 1'b1;
            ST_DOSE:  begin a.lock = 1'b1; a.valve = 1'b1; a.hatch = 1'b1; end
            ST_FILL:  begin a.lock = 1'b1; a.valve = 1'b1; end
            ST_HEAT:  begin a.lock = 1'b1; a.heater = 1'b1; end
            ST_WASH:  a.lock = 1'b1;
            ST_DRAIN: begin a.lock = 1'b1; a.pump = 1'b1; end
            default:  a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/wm_prog_decode.sv
module wm_prog_decode
    import wm_pkg::*;
#(
    parameter int PROG_W = 2
) (
    input  logic [PROG_W-1:0] prog,
    output prog_cfg_t         cfg
);
    // Bit 0 selects heating, bit 1 selects detergent
    always_comb begin
        cfg.use_heat = prog[0];
        cfg.use_soap = prog[1];
    end

endmodule

// File: rtl/wm_motor_pattern.sv
module wm_motor_pattern
    import wm_pkg::*;
#(
    parameter int PROG_W = 2,
    parameter int STEPS  = 4,
    parameter int UNIT   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              active,
    input  logic [PROG_W-1:0] prog,
    output motor_cmd_t        cmd,
    output logic              last_done
);
    localparam int NPROG = 1 << PROG_W;
    localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1;

    motor_step_t tbl [NPROG][STEPS];

    genvar gp, gs;
    generate
        for (gp = 0; gp < NPROG; gp++) begin : g_prog
            for (gs = 0; gs < STEPS; gs++) begin : g_step
                assign tbl[gp][gs] = step_of(gp, gs, UNIT);
            end
        end
    endgenerate

    logic [IDX_W-1:0] idx_q;
    logic [DUR_W-1:0] cnt_q;
    motor_step_t      cur;
    logic             step_end;
    logic             last_step;

    assign cur       = tbl[prog][idx_q];
    assign step_end  = (cnt_q == cur.dur - DUR_W'(1));
    assign last_step = (idx_q == IDX_W'(STEPS - 1));
    assign last_done = active && tick && step_end && last_step;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            idx_q <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            if (step_end) begin
                cnt_q <= '0;
                idx_q <= last_step ? '0 : idx_q + IDX_W'(1);
            end else begin
                cnt_q <= cnt_q + DUR_W'(1);
            end
        end
    end

    assign cmd = active ? motor_cmd_t'{rev: cur.rev, speed: cur.speed} : '0;

endmodule

// File: rtl/wm_cycle_ctrl.sv
module wm_cycle_ctrl
    import wm_pkg::*;
#(
    parameter int PROG_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start,
    input  logic [PROG_W-1:0] prog_sel,
    input  prog_cfg_t         cfg,
    input  logic              soap_released,
    input  logic              water_full,
    input  logic              temp_reached,
    input  logic              drum_empty,
    input  logic              wash_done,
    output cyc_state_t        state,
    output logic [PROG_W-1:0] prog_q,
    output logic              done_q
);
    cyc_state_t nxt;

    always_comb begin
        nxt = state;
        if (tick) begin
            case (state)
                ST_IDLE:    if (start)         nxt = ST_LOCK;
                ST_LOCK:                       nxt = cfg.use_soap ? ST_DOSE : ST_FILL;
                ST_DOSE:    if (soap_released) nxt = ST_FILL;
                ST_FILL:    if (water_full)    nxt = cfg.use_heat ? ST_HEAT : ST_WASH;
                ST_HEAT:    if (temp_reached)  nxt = ST_WASH;
                ST_WASH:    if (wash_done)     nxt = ST_DRAIN;
                ST_DRAIN:   if (drum_empty)    nxt = ST_RELEASE;
                ST_RELEASE:                    nxt = ST_IDLE;
                default:                       nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            prog_q <= '0;
            done_q <= 1'b0;
        end else begin
            state  <= nxt;
            done_q <= tick && (state == ST_RELEASE);
            if (tick && start && (state == ST_IDLE))
                prog_q <= prog_sel;
        end
    end

endmodule

// File: rtl/wm_cycle_seq.sv
module wm_cycle_seq
    import wm_pkg::*;
#(
    parameter int PROG_W = 2,
    parameter int STEPS  = 4,
    parameter int UNIT   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start,
    input  logic [PROG_W-1:0] prog_sel,
    input  logic              soap_released,
    input  logic              water_full,
    input  logic              temp_reached,
    input  logic              drum_empty,
    output logic              door_lock,
    output logic              fill_valve,
    output logic              soap_hatch,
    output logic              heater_on,
    output logic              drain_pump,
    output logic              motor_rev,
    output logic [SPD_W-1:0]  motor_speed,
    output logic              cycle_done
);
    cyc_state_t        state;
    logic [PROG_W-1:0] prog_q;
    prog_cfg_t         cfg;
    motor_cmd_t        mcmd;
    logic              wash_done;
    act_t              act;

    wm_prog_decode #(.PROG_W(PROG_W)) u_decode (
        .prog (prog_q),
        .cfg  (cfg)
    );

    wm_cycle_ctrl #(.PROG_W(PROG_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .tick          (tick),
        .start         (start),
        .prog_sel      (prog_sel),
        .cfg           (cfg),
        .soap_released (soap_released),
        .water_full    (water_full),
        .temp_reached  (temp_reached),
        .drum_empty    (drum_empty),
        .wash_done     (wash_done),
        .state         (state),
        .prog_q        (prog_q),
        .done_q        (cycle_done)
    );

    wm_motor_pattern #(.PROG_W(PROG_W), .STEPS(STEPS), .UNIT(UNIT)) u_motor (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .active    (state == ST_WASH),
        .prog      (prog_q),
        .cmd       (mcmd),
        .last_done (wash_done)
    );

    assign act         = act_of(state);
    assign door_lock   = act.lock;
    assign fill_valve  = act.valve;
    assign soap_hatch  = act.hatch;
    assign heater_on   = act.heater;
    assign drain_pump  = act.pump;
    assign motor_rev   = mcmd.rev;
    assign motor_speed = mcmd.speed;

endmodule

// File: rtl/wm_cycle_seq_chk.sv
module wm_cycle_seq_chk
    import wm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             door_lock,
    input logic             fill_valve,
    input logic             soap_hatch,
    input logic             heater_on,
    input logic             drain_pump,
    input logic             motor_rev,
    input logic [SPD_W-1:0] motor_speed,
    input logic             cycle_done
);
    // R3
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable({door_lock, fill_valve, soap_hatch, heater_on, drain_pump, motor_rev, motor_speed}));

    // R11
    heater_alone_chk: assert property (@(posedge clk) disable iff (rst)
        heater_on |-> (!fill_valve && !drain_pump && motor_speed == '0));

    // R11
    motor_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (motor_speed != '0) |-> door_lock);

    // R4
    hatch_with_valve_chk: assert property (@(posedge clk) disable iff (rst)
        soap_hatch |-> (fill_valve && door_lock));

    // R8
    pump_no_fill_chk: assert property (@(posedge clk) disable iff (rst)
        drain_pump |-> (door_lock && !fill_valve));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        cycle_done |=> !cycle_done);

    // R9
    done_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        cycle_done |-> !door_lock);

endmodule

bind wm_cycle_seq wm_cycle_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .door_lock   (door_lock),
    .fill_valve  (fill_valve),
    .soap_hatch  (soap_hatch),
    .heater_on   (heater_on),
    .drain_pump  (drain_pump),
    .motor_rev   (motor_rev),
    .motor_speed (motor_speed),
    .cycle_done  (cycle_done)
);

// File: tb/tb_wm_cycle_seq.sv
module tb_wm_cycle_seq;
    localparam int PROG_W = 2;
    localparam int STEPS  = 4;
    localparam int UNIT   = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic start = 1'b0;
    logic [PROG_W-1:0] prog_sel = '0;
    logic soap_released = 1'b0;
    logic water_full = 1'b0;
    logic temp_reached = 1'b0;
    logic drum_empty = 1'b0;
    logic door_lock, fill_valve, soap_hatch, heater_on, drain_pump, motor_rev;
    logic [1:0] motor_speed;
    logic cycle_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    wm_cycle_seq #(.PROG_W(PROG_W), .STEPS(STEPS), .UNIT(UNIT)) dut (
        .clk(clk), .rst(rst), .tick(tick), .start(start), .prog_sel(prog_sel),
        .soap_released(soap_released), .water_full(water_full),
        .temp_reached(temp_reached), .drum_empty(drum_empty),
        .door_lock(door_lock), .fill_valve(fill_valve), .soap_hatch(soap_hatch),
        .heater_on(heater_on), .drain_pump(drain_pump), .motor_rev(motor_rev),
        .motor_speed(motor_speed), .cycle_done(cycle_done)
    );

    function automatic logic [7:0] ex(input bit l, input bit v, input bit h,
                                      input bit ht, input bit pm, input bit rv, input int sp);
        return {l, v, h, ht, pm, rv, 2'(sp)};
    endfunction

    task automatic chk(input string tag, input logic [7:0] e);
        logic [7:0] got;
        got = {door_lock, fill_valve, soap_hatch, heater_on, drain_pump, motor_rev, motor_speed};
        checks++;
        if (got !== e) begin
            errors++;
            $display("FAIL %s: outputs got %b expected %b", tag, got, e);
        end
    endtask

    task automatic chk_done(input string tag, input logic e);
        checks++;
        if (cycle_done !== e) begin
            errors++;
            $display("FAIL %s: cycle_done got %b expected %b", tag, cycle_done, e);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic test_reset_state();
        chk("R1 reset outputs", ex(0,0,0,0,0,0,0));
        chk_done("R1 reset done", 1'b0);
        start = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 start without tick", ex(0,0,0,0,0,0,0));
        start = 1'b0;
    endtask

    task automatic run_cycle(input int p);
        bit soap, heat;
        soap = ((p >> 1) & 1) == 1;
        heat = (p & 1) == 1;
        prog_sel = PROG_W'(p);
        start = 1'b1;
        pulse_tick();
        start = 1'b0;
        prog_sel = ~PROG_W'(p);
        chk("R2 lock first", ex(1,0,0,0,0,0,0));
        if (soap) begin
            pulse_tick();
            chk("R4 dosing", ex(1,1,1,0,0,0,0));
            pulse_tick();
            chk("R4 dosing waits", ex(1,1,1,0,0,0,0));
            soap_released = 1'b1;
            repeat (2) @(negedge clk);
            chk("R3 release without tick", ex(1,1,1,0,0,0,0));
            pulse_tick();
            soap_released = 1'b0;
            chk("R4 dose to fill", ex(1,1,0,0,0,0,0));
        end else begin
            pulse_tick();
            chk("R4 dose skipped", ex(1,1,0,0,0,0,0));
        end
        pulse_tick();
        chk("R5 fill waits", ex(1,1,0,0,0,0,0));
        water_full = 1'b1;
        repeat (2) @(negedge clk);
        chk("R3 full without tick", ex(1,1,0,0,0,0,0));
        pulse_tick();
        water_full = 1'b0;
        if (heat) begin
            chk("R6 heating", ex(1,0,0,1,0,0,0));
            pulse_tick();
            chk("R6 heating waits", ex(1,0,0,1,0,0,0));
            temp_reached = 1'b1;
            pulse_tick();
            temp_reached = 1'b0;
        end
        start = 1'b1;
        for (int i = 0; i < STEPS; i++) begin
            int spd, dur;
            spd = ((p + i) % 3) + 1;
            dur = UNIT * (1 + ((p + i) % 2));
            for (int k = 0; k < dur; k++) begin
                chk(heat ? "R7 wash step" : "R6 skip then R7 wash step",
                    ex(1,0,0,0,0,(i % 2) == 1, spd));
                pulse_tick();
            end
        end
        start = 1'b0;
        chk("R8 R10 drain after wash", ex(1,0,0,0,1,0,0));
        pulse_tick();
        chk("R8 drain waits", ex(1,0,0,0,1,0,0));
        drum_empty = 1'b1;
        pulse_tick();
        drum_empty = 1'b0;
        chk("R9 release", ex(0,0,0,0,0,0,0));
        chk_done("R9 no done yet", 1'b0);
        pulse_tick();
        chk_done("R9 done pulse", 1'b1);
        chk("R9 idle", ex(0,0,0,0,0,0,0));
        @(negedge clk);
        chk_done("R9 done one clock", 1'b0);
    endtask

    task automatic test_mid_reset();
        prog_sel = 2'd3;
        start = 1'b1;
        pulse_tick();
        start = 1'b0;
        pulse_tick();
        chk("R4 before reset", ex(1,1,1,0,0,0,0));
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        chk("R1 mid-cycle reset", ex(0,0,0,0,0,0,0));
        pulse_tick();
        chk("R2 no start stays idle", ex(0,0,0,0,0,0,0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset_state();
        run_cycle(0);
        run_cycle(3);
        run_cycle(1);
        run_cycle(2);
        test_mid_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule